// File: doc/BRIEF.md
# Dual-NCO Chip Tracking Loop

This block is a second-order digital loop that keeps a receive numerically controlled oscillator (NCO) aligned with the range-clock component of a loop-back ranging signal. A second, transmit NCO runs open-loop from the same clock at the nominal chip-rate word. Each mid-phase integrator sample is multiplied by the sign of the chip transition that the local code expects, so no separate transition detector is needed. The product feeds a proportional-plus-integral filter, and the filter output is added to the nominal rate word to steer the receive NCO.

A single calibration start strobe clears both phase accumulators, the loop state and the loop term in the same cycle. After that, the code generators driven by the two tick outputs start from an identical phase. From then on, the loop term output is the sum of every correction applied to the receive NCO. It therefore equals the receive-minus-transmit phase difference, so 2πE/2^N radians, or E·Ts/2^N seconds, of loop-back delay can be sent down in telemetry.

Top module: `ctl_dual_nco_loop`

## Requirements
- R1: While rst_n is low, all outputs are zero: both ticks low, both phases 0, loop_e 0.
- R2: chip_prev and chip_next use bit value 1 for a +1 chip and 0 for a −1 chip. A 0→1 pair gives error = +smp_data, a 1→0 pair gives error = −smp_data, and equal chips give error 0, which leaves the loop unchanged.
- R3: Negating the most negative sample on a 1→0 pair saturates to the most positive value (−32768 gives +32767 with a 16-bit sample).
- R4: A valid sample taken at clock edge k gives a one-cycle proportional correction error·gain_p. That correction is added to the receive NCO step at edge k+2 and is visible on rx_phase and loop_e after that edge.
- R5: Every valid error adds error·gain_i to a signed integrator of INT_W bits, which saturates at its limits. The integrator value is added to the receive step on every cycle, starting one edge after the update.
- R6: On every edge, tx_phase advances by rate_nom modulo 2^N. tx_tick is high for one cycle exactly when that addition carries out.
- R7: On every edge, rx_phase advances by rate_nom plus the sign-extended correction, modulo 2^N. rx_tick marks each carry out.
- R8: loop_e accumulates every correction, modulo 2^N, and always equals rx_phase − tx_phase.
- R9: cal_start, sampled at an edge, forces both phases, both ticks, loop_e, the pending error and the integrator to zero at that edge.
- R10: A cycle with smp_valid low changes neither the integrator nor the proportional term, whatever the data and chip inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Loop clock, one NCO update per edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_start | input | 1 | Synchronous strobe that clears both NCOs and the loop state |
| smp_valid | input | 1 | Mid-phase sample qualifier |
| smp_data | input | SW (16) | Signed mid-phase integrator output |
| chip_prev | input | 1 | Expected chip before the sampled boundary (1 = +1) |
| chip_next | input | 1 | Expected chip after the sampled boundary (1 = +1) |
| rate_nom | input | N (32) | Nominal chip-rate frequency word |
| gain_p | input | GW (8) | Unsigned proportional gain |
| gain_i | input | GW (8) | Unsigned integral gain |
| tx_tick | output | 1 | Transmit NCO overflow pulse |
| rx_tick | output | 1 | Receive NCO overflow pulse |
| tx_phase | output | N (32) | Transmit phase accumulator |
| rx_phase | output | N (32) | Receive phase accumulator |
| loop_e | output | N (32) | Accumulated loop term, receive minus transmit phase |

## Verification
Single samples are applied on rising, falling and equal chip pairs with one gain active at a time. This separates the sign rule from the proportional one-shot and from the integrating path. The most negative sample on a falling pair, and long runs of full-scale samples under maximum integral gain, drive both saturation points in each direction. A sample with the qualifier low, a mid-run start strobe, and a long pseudo-random stretch with changing gains, rates and strobes all check that the three phase-related outputs stay consistent with each other and with the cycle-by-cycle prediction.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

  typedef enum logic [1:0] {
    TR_NONE = 2'd0,
    TR_RISE = 2'd1,
    TR_FALL = 2'd2
  } trans_e;

  localparam int NCO_TX  = 0;
  localparam int NCO_RX  = 1;
  localparam int NCO_CNT = 2;

  // chip bit 1 stands for a +1 chip, 0 for a -1 chip
  function automatic trans_e classify(input logic prev_c, input logic next_c);
    if (prev_c == next_c) return TR_NONE;
    else if (next_c)      return TR_RISE;
    else                  return TR_FALL;
  endfunction

endpackage

// File: rtl/ctl_nco.sv
module ctl_nco #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init,
  input  logic [N-1:0] rate,
  output logic [N-1:0] phase,
  output logic         tick
);

  logic [N-1:0] phase_q, phase_n;
  logic         tick_q, tick_n;
  logic [N:0]   sum_w;

  always_comb begin
    sum_w   = {1'b0, phase_q} + {1'b0, rate};
    phase_n = sum_w[N-1:0];
    tick_n  = sum_w[N];
    if (init) begin
      phase_n = '0;
      tick_n  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      tick_q  <= 1'b0;
    end else begin
      phase_q <= phase_n;
      tick_q  <= tick_n;
    end
  end

  assign phase = phase_q;
  assign tick  = tick_q;

  // R6
  nco_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> (phase_q < $past(phase_q)));

endmodule

// File: rtl/ctl_phase_det.sv
module ctl_phase_det
  import ctl_pkg::*;
#(
  parameter int SW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 smp_valid,
  input  logic signed [SW-1:0] smp,
  input  logic                 chip_prev,
  input  logic                 chip_next,
  output logic signed [SW-1:0] err,
  output logic                 err_vld
);

  localparam logic signed [SW-1:0] S_MAX = {1'b0, {(SW-1){1'b1}}};
  localparam logic signed [SW-1:0] S_MIN = {1'b1, {(SW-1){1'b0}}};

  trans_e                tr_w;
  logic signed [SW-1:0]  prod_w;
  logic signed [SW-1:0]  err_q, err_n;
  logic                  vld_q, vld_n;

  always_comb begin
    tr_w = classify(chip_prev, chip_next);
    unique case (tr_w)
      TR_RISE: prod_w = smp;
      TR_FALL: prod_w = (smp == S_MIN) ? S_MAX : -smp;
      default: prod_w = '0;
    endcase
  end

  always_comb begin
    err_n = err_q;
    vld_n = smp_valid;
    if (clr) begin
      err_n = '0;
      vld_n = 1'b0;
    end else if (smp_valid) begin
      err_n = prod_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
      vld_q <= 1'b0;
    end else begin
      err_q <= err_n;
      vld_q <= vld_n;
    end
  end

  assign err     = err_q;
  assign err_vld = vld_q;

  // R2
  no_trans_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !clr && (chip_prev == chip_next)) |=> (err_q == '0));

  // R3
  neg_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !clr && chip_prev && !chip_next && (smp == S_MIN)) |=> (err_q == S_MAX));

endmodule

// File: rtl/ctl_loop_filter.sv
module ctl_loop_filter #(
  parameter int SW    = 16,
  parameter int GW    = 8,
  parameter int INT_W = 28
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  err_vld,
  input  logic signed [SW-1:0]  err,
  input  logic [GW-1:0]         gain_p,
  input  logic [GW-1:0]         gain_i,
  output logic signed [INT_W:0] corr
);

  localparam int PW = SW + GW + 1;
  localparam logic signed [INT_W-1:0] I_MAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic signed [INT_W-1:0] I_MIN = {1'b1, {(INT_W-1){1'b0}}};

  logic signed [PW-1:0]    pp_w, pi_w;
  logic signed [INT_W:0]   isum_w;
  logic signed [PW-1:0]    prop_q, prop_n;
  logic signed [INT_W-1:0] int_q, int_n;

  assign pp_w   = PW'(err) * PW'($signed({1'b0, gain_p}));
  assign pi_w   = PW'(err) * PW'($signed({1'b0, gain_i}));
  assign isum_w = (INT_W+1)'(int_q) + (INT_W+1)'(pi_w);

  always_comb begin
    prop_n = '0;
    int_n  = int_q;
    if (clr) begin
      int_n = '0;
    end else if (err_vld) begin
      prop_n = pp_w;
      if (isum_w[INT_W] != isum_w[INT_W-1])
        int_n = isum_w[INT_W] ? I_MIN : I_MAX;
      else
        int_n = isum_w[INT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prop_q <= '0;
      int_q  <= '0;
    end else begin
      prop_q <= prop_n;
      int_q  <= int_n;
    end
  end

  assign corr = (INT_W+1)'(prop_q) + (INT_W+1)'(int_q);

  // R10
  int_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !err_vld) |=> $stable(int_q));

  // R4
  prop_oneshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err_vld |=> (prop_q == '0));

endmodule

// File: rtl/ctl_dual_nco_loop.sv
module ctl_dual_nco_loop
  import ctl_pkg::*;
#(
  parameter int N     = 32,
  parameter int SW    = 16,
  parameter int GW    = 8,
  parameter int INT_W = 28
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cal_start,
  input  logic                 smp_valid,
  input  logic signed [SW-1:0] smp_data,
  input  logic                 chip_prev,
  input  logic                 chip_next,
  input  logic [N-1:0]         rate_nom,
  input  logic [GW-1:0]        gain_p,
  input  logic [GW-1:0]        gain_i,
  output logic                 tx_tick,
  output logic                 rx_tick,
  output logic [N-1:0]         tx_phase,
  output logic [N-1:0]         rx_phase,
  output logic [N-1:0]         loop_e
);

  logic signed [SW-1:0]  err_w;
  logic                  err_vld_w;
  logic signed [INT_W:0] corr_w;
  logic [N-1:0]          corr_ext;
  logic [N-1:0]          nco_rate  [NCO_CNT];
  logic [N-1:0]          nco_phase [NCO_CNT];
  logic                  nco_tick  [NCO_CNT];
  logic [N-1:0]          e_q, e_n;

  ctl_phase_det #(.SW(SW)) u_pdet (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cal_start),
    .smp_valid (smp_valid),
    .smp       (smp_data),
    .chip_prev (chip_prev),
    .chip_next (chip_next),
    .err       (err_w),
    .err_vld   (err_vld_w)
  );

  ctl_loop_filter #(.SW(SW), .GW(GW), .INT_W(INT_W)) u_filt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (cal_start),
    .err_vld (err_vld_w),
    .err     (err_w),
    .gain_p  (gain_p),
    .gain_i  (gain_i),
    .corr    (corr_w)
  );

  assign corr_ext          = N'(corr_w);
  assign nco_rate[NCO_TX]  = rate_nom;
  assign nco_rate[NCO_RX]  = rate_nom + corr_ext;

  for (genvar g = 0; g < NCO_CNT; g++) begin : g_nco
    ctl_nco #(.N(N)) u_nco (
      .clk   (clk),
      .rst_n (rst_n),
      .init  (cal_start),
      .rate  (nco_rate[g]),
      .phase (nco_phase[g]),
      .tick  (nco_tick[g])
    );
  end

  always_comb begin
    e_n = e_q + corr_ext;
    if (cal_start) e_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) e_q <= '0;
    else        e_q <= e_n;
  end

  assign tx_tick  = nco_tick[NCO_TX];
  assign rx_tick  = nco_tick[NCO_RX];
  assign tx_phase = nco_phase[NCO_TX];
  assign rx_phase = nco_phase[NCO_RX];
  assign loop_e   = e_q;

  // R8
  e_tracks_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_e == (rx_phase - tx_phase));

  // R9
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> (tx_phase == '0 && rx_phase == '0 && loop_e == '0 && !tx_tick && !rx_tick));

endmodule

// File: tb/ctl_dual_nco_loop_tb.sv
module ctl_dual_nco_loop_tb;

  localparam int N = 32;
  localparam int SW = 16;
  localparam int GW = 8;
  localparam int INT_W = 28;
  localparam longint IMAX = (64'sd1 <<< (INT_W-1)) - 1;
  localparam longint IMIN = -(64'sd1 <<< (INT_W-1));

  logic clk = 1'b0;
  logic rst_n;
  logic cal_start, smp_valid, chip_prev, chip_next;
  logic signed [SW-1:0] smp_data;
  logic [N-1:0] rate_nom;
  logic [GW-1:0] gain_p, gain_i;
  logic tx_tick, rx_tick;
  logic [N-1:0] tx_phase, rx_phase, loop_e;

  always #4 clk = ~clk;

  ctl_dual_nco_loop #(.N(N), .SW(SW), .GW(GW), .INT_W(INT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .smp_valid(smp_valid),
    .smp_data(smp_data), .chip_prev(chip_prev), .chip_next(chip_next),
    .rate_nom(rate_nom), .gain_p(gain_p), .gain_i(gain_i),
    .tx_tick(tx_tick), .rx_tick(rx_tick), .tx_phase(tx_phase),
    .rx_phase(rx_phase), .loop_e(loop_e)
  );

  typedef struct {
    logic tt; logic rt; logic [N-1:0] tp; logic [N-1:0] rp; logic [N-1:0] e;
  } exp_t;

  exp_t   sb_q[$];
  int     n_chk = 0;
  int     n_bad = 0;
  string  cur_req = "R1";
  bit     done = 0;

  // prediction state
  longint m_err, m_prop, m_int;
  bit     m_vld, m_tt, m_rt;
  logic [N-1:0] m_tp, m_rp, m_e;

  task automatic model_clear();
    m_err = 0; m_prop = 0; m_int = 0; m_vld = 0; m_tt = 0; m_rt = 0;
    m_tp = '0; m_rp = '0; m_e = '0;
  endtask

  task automatic push_exp();
    exp_t x;
    x.tt = m_tt; x.rt = m_rt; x.tp = m_tp; x.rp = m_rp; x.e = m_e;
    sb_q.push_back(x);
  endtask

  task automatic model_edge();
    longint corr, s, gp, gi, ne, acc;
    logic [N:0] ts, rs;
    logic [N-1:0] rr;
    corr = m_prop + m_int;
    s  = longint'(smp_data);
    gp = longint'(gain_p);
    gi = longint'(gain_i);
    // R2 sign rule, R3 saturation of the negation
    if (chip_prev == chip_next) ne = 0;
    else if (chip_next)        ne = s;
    else                       ne = (s == -32768) ? 32767 : -s;
    if (cal_start) begin
      model_clear();
    end else begin
      ts = {1'b0, m_tp} + {1'b0, rate_nom};
      rr = rate_nom + N'(corr);
      rs = {1'b0, m_rp} + {1'b0, rr};
      m_tp = ts[N-1:0]; m_tt = ts[N];
      m_rp = rs[N-1:0]; m_rt = rs[N];
      m_e  = m_e + N'(corr);
      if (m_vld) begin
        m_prop = m_err * gp;
        acc = m_int + m_err * gi;
        if (acc > IMAX) acc = IMAX;
        if (acc < IMIN) acc = IMIN;
        m_int = acc;
      end else begin
        m_prop = 0;
      end
      m_vld = smp_valid;
      if (smp_valid) m_err = ne;
    end
  endtask

  task automatic step(input bit st, input bit v, input int s, input bit cp, input bit cn);
    cal_start = st; smp_valid = v; smp_data = SW'(s); chip_prev = cp; chip_next = cn;
    @(posedge clk);
    model_edge();
    push_exp();
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  task automatic chk(input bit ok, input string fld, input string req,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s [%s] %s act=%0h exp=%0h t=%0t", req, cur_req, fld, act, expv, $time);
    end
  endtask

  // monitor: compare each predicted item against the outputs
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t x;
      x = sb_q.pop_front();
      chk(tx_tick == x.tt,  "tx_tick",  "R6", longint'(tx_tick),  longint'(x.tt));
      chk(tx_phase == x.tp, "tx_phase", "R6", longint'(tx_phase), longint'(x.tp));
      chk(rx_tick == x.rt,  "rx_tick",  "R7", longint'(rx_tick),  longint'(x.rt));
      chk(rx_phase == x.rp, "rx_phase", "R7", longint'(rx_phase), longint'(x.rp));
      chk(loop_e == x.e,    "loop_e",   "R8", longint'(loop_e),   longint'(x.e));
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL %s watchdog act=hung exp=finished", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    rst_n = 1'b0; cal_start = 0; smp_valid = 0; smp_data = '0;
    chip_prev = 0; chip_next = 0; rate_nom = 32'h1000_0000; gain_p = '0; gain_i = '0;
    model_clear();
    // R1: outputs held at zero in reset
    cur_req = "R1";
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); push_exp(); @(negedge clk);
    end
    rst_n = 1'b1;

    cur_req = "R9";  step(1, 0, 0, 0, 0);
    cur_req = "R6";  idle(40);           // open-loop NCOs, ticks every 16 edges
    cur_req = "R4";  gain_p = 8'd4;  step(0, 1, 100, 0, 1);  idle(6);
    cur_req = "R2";  step(0, 1, 100, 1, 0);  idle(6);        // falling pair
    cur_req = "R2";  step(0, 1, 500, 1, 1);  idle(3);        // no transition
                     step(0, 1, 500, 0, 0);  idle(3);
    cur_req = "R10"; step(0, 0, 1234, 0, 1); idle(4);        // qualifier low
    cur_req = "R5";  gain_i = 8'd3;
    for (int i = 0; i < 5; i++) step(0, 1, 50, 0, 1);
    idle(10);
    cur_req = "R3";  step(0, 1, -32768, 1, 0); idle(5);
    cur_req = "R9";  step(1, 1, 777, 0, 1);    idle(10);     // mid-run strobe
    cur_req = "R5";  gain_p = 8'hFF; gain_i = 8'hFF;
    for (int i = 0; i < 40; i++) step(0, 1, 32767, 0, 1);     // positive limit
    for (int i = 0; i < 60; i++) step(0, 1, 32767, 1, 0);     // negative limit
    idle(5);
    cur_req = "R7";  rate_nom = 32'hFFFF_FFF0; gain_p = 8'd1; gain_i = 8'd0;
    for (int i = 0; i < 20; i++) step(0, 1, 20, i[0], ~i[0]);
    idle(5);

    cur_req = "R8";
    lf = 32'hACE1_2345;
    for (int i = 0; i < 4000; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      if (i % 64 == 0) begin
        gain_p = lf[7:0]; gain_i = lf[15:8] & 8'h1F; rate_nom = {4'h0, lf[27:0]};
      end
      step(lf[31:22] == 10'd0, lf[3], int'($signed(lf[23:8])), lf[5], lf[6]);
    end
    idle(3);

    while (sb_q.size() > 0) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule